// File: doc/BRIEF.md
# Mux-tree thermometer-to-binary encoder

This block takes the thermometer word of a flash converter's comparator bank, with 2^N-1 bits for an N-bit result, and turns it into a binary count. The conversion happens in two steps. A sparse network of 2:1 multiplexers first forms a Gray code, and several of the multiplexer data inputs are tied to logic zero. An XOR ladder then turns that Gray code into binary. The network needs 2^(N-1)-1 multiplexers and N-1 XOR gates. The default of N = 4 gives seven multiplexers and three XORs for a 15-bit input.

The result and a valid flag are registered once. A word presented on one clock edge appears on the outputs after the next edge. The block does not detect or correct bubbles. A word that is not a thermometer word still gives a fixed result, and that result follows from the multiplexer equations. Thermometer bit Tk (k counted from 1) sits on `therm_i[k-1]`.

Top module: `tgb_encoder`

## Requirements
- R1: The binary MSB `bin_o[3]` (with N = 4) equals the midpoint bit T8 (`therm_i[7]`) sampled on the previous clock edge.
- R2: For a valid thermometer input with its lowest k bits set, `bin_o` equals k one cycle later, for every k from 0 to 15. The all-zero word gives 0 and the all-ones word (0x7FFF) gives 15.
- R3: `bin_vld_o` equals `therm_vld_i` sampled on the previous clock edge. `bin_o` follows the previous cycle's input with exactly one cycle of latency.
- R4: While `rst` is high at a rising edge, `bin_o` and `bin_vld_o` become 0 after that edge, whatever the inputs are.
- R5: A bubbled input is encoded by the multiplexer equations, with no error indication:
  - G3 = T8
  - G2 = T4 & ~T12
  - G1 = T6 ? (T14 ? 0 : T10) : T2
  - G0 = T3 ? (T7 ? (T11 ? (T15 ? 0 : T13) : T9) : T5) : T1
  - B3 = G3, and Bi = Bi+1 ^ Gi for each lower bit.
  
  From these equations, 0x008F gives 11, 0x4001 gives 1 and 0x5555 gives 0.
- R6: `bin_o` is loaded on every edge, whatever the value of `therm_vld_i`. A word presented with the valid input low still appears on `bin_o` one cycle later, with `bin_vld_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_i | input | 2^B_W-1 (15) | Thermometer word, bit k-1 holds Tk |
| therm_vld_i | input | 1 | Input word qualifier |
| bin_o | output | B_W (4) | Registered binary result |
| bin_vld_o | output | 1 | Registered qualifier, one cycle after `therm_vld_i` |

## Verification
The assertions check every cycle that the outputs are cleared after a reset edge and that the valid flag lags its input by one cycle. They also check that the MSB tracks the midpoint bit, and that any input that happens to be a proper thermometer word is encoded to its ones count. Only the bench scenarios can show three further behaviours. The first is the exact results of bubbled words, which follow from the multiplexer equations. The second is that a word presented with the valid input low still reaches `bin_o`. The third is that a reset in the middle of a run overrides live input.

// File: rtl/tgb_pkg.sv
package tgb_pkg;

  // Thermometer word width for a given binary width.
  function automatic int therm_width(input int bin_w);
    return (1 << bin_w) - 1;
  endfunction

  // Number of 2:1 cells the Gray network needs for a given binary width.
  function automatic int mux_count(input int bin_w);
    return (1 << (bin_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/tgb_mux2.sv
module tgb_mux2 (
  input  logic sel_i,
  input  logic d0_i,
  input  logic d1_i,
  output logic y_o
);

  always_comb begin
    y_o = sel_i ? d1_i : d0_i;
  end

endmodule

// File: rtl/tgb_gray_net.sv
// Sparse mux network. For Gray bit j below the top one, cell m takes data
// bit T[2^j + m*2^(j+2)], selected by the bit 2^(j+1) positions above it.
// The innermost cell's "1" input is tied low.
module tgb_gray_net #(
  parameter int B_W = 4,
  localparam int T_W = tgb_pkg::therm_width(B_W)
) (
  input  logic [T_W-1:0] therm_i,
  output logic [B_W-1:0] gray_o
);

  // The top Gray bit is the midpoint comparator.
  assign gray_o[B_W-1] = therm_i[(1 << (B_W - 1)) - 1];

  for (genvar j = 0; j < B_W - 1; j++) begin : g_bit
    localparam int CELLS = 1 << (B_W - j - 2);
    localparam int STEP  = 1 << (j + 2);
    localparam int BASE  = 1 << j;
    localparam int SOFS  = 1 << (j + 1);

    logic [CELLS:0] link;
    assign link[CELLS] = 1'b0;

    for (genvar m = 0; m < CELLS; m++) begin : g_cell
      tgb_mux2 i_cell (
        .sel_i (therm_i[BASE + m * STEP + SOFS - 1]),
        .d0_i  (therm_i[BASE + m * STEP - 1]),
        .d1_i  (link[m + 1]),
        .y_o   (link[m])
      );
    end

    assign gray_o[j] = link[0];
  end

endmodule

// File: rtl/tgb_gray2bin.sv
module tgb_gray2bin #(
  parameter int B_W = 4
) (
  input  logic [B_W-1:0] gray_i,
  output logic [B_W-1:0] bin_o
);

  always_comb begin
    bin_o[B_W-1] = gray_i[B_W-1];
    for (int i = B_W - 2; i >= 0; i--) begin
      bin_o[i] = bin_o[i + 1] ^ gray_i[i];
    end
  end

endmodule

// File: rtl/tgb_out_reg.sv
module tgb_out_reg #(
  parameter int B_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [B_W-1:0] bin_d,
  input  logic           vld_d,
  output logic [B_W-1:0] bin_q,
  output logic           vld_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q <= '0;
      vld_q <= 1'b0;
    end else begin
      bin_q <= bin_d;
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/tgb_encoder.sv
module tgb_encoder #(
  parameter int B_W = 4,
  localparam int T_W = tgb_pkg::therm_width(B_W)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [T_W-1:0] therm_i,
  input  logic           therm_vld_i,
  output logic [B_W-1:0] bin_o,
  output logic           bin_vld_o
);

  logic [B_W-1:0] gray_w;
  logic [B_W-1:0] bin_w;

  tgb_gray_net #(.B_W(B_W)) i_gray (
    .therm_i (therm_i),
    .gray_o  (gray_w)
  );

  tgb_gray2bin #(.B_W(B_W)) i_g2b (
    .gray_i (gray_w),
    .bin_o  (bin_w)
  );

  tgb_out_reg #(.B_W(B_W)) i_oreg (
    .clk   (clk),
    .rst   (rst),
    .bin_d (bin_w),
    .vld_d (therm_vld_i),
    .bin_q (bin_o),
    .vld_q (bin_vld_o)
  );

endmodule

// File: rtl/tgb_encoder_chk.sv
module tgb_encoder_chk #(
  parameter int B_W = 4,
  localparam int T_W = tgb_pkg::therm_width(B_W)
) (
  input logic           clk,
  input logic           rst,
  input logic [T_W-1:0] therm_i,
  input logic           therm_vld_i,
  input logic [B_W-1:0] bin_o,
  input logic           bin_vld_o
);

  localparam int MID = (1 << (B_W - 1)) - 1;

  logic [T_W-1:0] therm_inc;
  logic           is_therm;
  assign therm_inc = therm_i + T_W'(1);
  assign is_therm  = ((therm_i & therm_inc) == '0);

  // R4: outputs cleared after a reset edge
  a_r4_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bin_o == '0 && !bin_vld_o));

  // R3: valid flag lags its input by one cycle
  a_r3_valid_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bin_vld_o == $past(therm_vld_i)));

  // R1: MSB follows the midpoint comparator
  a_r1_msb_mid: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bin_o[B_W-1] == $past(therm_i[MID])));

  // R2: proper thermometer words encode to their ones count
  a_r2_count: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(is_therm)) |-> (32'(bin_o) == $countones($past(therm_i))));

endmodule

bind tgb_encoder tgb_encoder_chk #(.B_W(B_W)) i_chk (
  .clk         (clk),
  .rst         (rst),
  .therm_i     (therm_i),
  .therm_vld_i (therm_vld_i),
  .bin_o       (bin_o),
  .bin_vld_o   (bin_vld_o)
);

// File: tb/test_tgb_encoder.sv
module test_tgb_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int B_W = 4;
  localparam int T_W = 15;
  localparam int WATCHDOG = 5000;

  typedef struct {
    logic [B_W-1:0] bin;
    logic           vld;
    int             due;
    string          tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [T_W-1:0] therm = '0;
  logic           tvld = 1'b0;
  logic [B_W-1:0] bin_o;
  logic           bin_vld_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t sb[$];

  tgb_encoder #(.B_W(B_W)) i_tgb_encoder (
    .clk         (clk),
    .rst         (rst),
    .therm_i     (therm),
    .therm_vld_i (tvld),
    .bin_o       (bin_o),
    .bin_vld_o   (bin_vld_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Drive just after an edge; the result is due at the following edge.
  task automatic drive(input logic [T_W-1:0] w, input logic v, input logic r,
                       input logic [B_W-1:0] eb, input logic ev, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    therm = w;
    tvld  = v;
    rst   = r;
    e.bin = eb;
    e.vld = ev;
    e.due = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare at the falling edge after the due rising edge.
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (bin_o !== e.bin || bin_vld_o !== e.vld) begin
          errors++;
          $display("FAIL %s: bin=%0d vld=%0b expected bin=%0d vld=%0b",
                   e.tag, bin_o, bin_vld_o, e.bin, e.vld);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: expired expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R4: reset state with inputs active
    therm = 15'h7FFF;
    tvld  = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bin_o !== '0 || bin_vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R4: bin=%0d vld=%0b expected bin=0 vld=0", bin_o, bin_vld_o);
    end

    // R2 / R1: every valid thermometer code, k = 0..15
    for (int k = 0; k <= 15; k++) begin
      drive(T_W'((32'd1 << k) - 1), 1'b1, 1'b0, B_W'(k), 1'b1, "R2 R1 code");
    end

    // R3 / R6: valid pattern varies; bin still updates with valid low
    drive(15'h001F, 1'b0, 1'b0, 4'd5,  1'b0, "R6 R3 vld-low");
    drive(15'h0FFF, 1'b0, 1'b0, 4'd12, 1'b0, "R6 R3 vld-low");
    drive(15'h0003, 1'b1, 1'b0, 4'd2,  1'b1, "R3 vld-high");
    drive(15'h00FF, 1'b0, 1'b0, 4'd8,  1'b0, "R6 R3 vld-low");
    drive(15'h3FFF, 1'b1, 1'b0, 4'd14, 1'b1, "R3 vld-high");

    // R5: bubbled words follow the mux equations
    drive(15'h008F, 1'b1, 1'b0, 4'd11, 1'b1, "R5 bubble 008F");
    drive(15'h4001, 1'b1, 1'b0, 4'd1,  1'b1, "R5 bubble 4001");
    drive(15'h5555, 1'b1, 1'b0, 4'd0,  1'b1, "R5 bubble 5555");
    drive(15'h0000, 1'b1, 1'b0, 4'd0,  1'b1, "R2 zero");

    // R4: mid-run reset overrides live input
    drive(15'h01FF, 1'b1, 1'b1, 4'd0,  1'b0, "R4 mid-run reset");
    drive(15'h7FFF, 1'b1, 1'b0, 4'd15, 1'b1, "R2 all-ones after reset");

    drive(15'h0000, 1'b0, 1'b0, 4'd0,  1'b0, "R3 idle");
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: left=%0d expected 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule